// File: doc/BRIEF.md
# Single-Address DMA Transfer Tracker

This block keeps the bookkeeping for a single-address DMA transfer inside a card host controller. Software programs a 32-bit system address, a block length with a power-of-two buffer boundary, a block count, a transfer mode and a host control DMA select. A start pulse then opens a transfer. The bus master and the card data lines are not modelled here. Each moved 32-bit word is shown by a `wordValid` strobe, and it is taken whenever `wordReady` is high.

Every taken word moves the address on by four bytes and the position inside the current block on by four bytes. A completed block lowers the block count when counting is in use. The transfer completes after the last block and sets a done status bit. If the address crosses the programmed boundary before the last word, the block sets a boundary status bit and stops taking words. It restarts when software writes the address register, and it goes on from the address written. Status bits are cleared by writing ones to them.

Top module: `sdma_xfer_tracker`

## Requirements
- R1: After reset the address, block count and status are zero, no transfer is active, and `wordReady` is low.
- R2: Writing the address register (select 0) while no transfer is active loads `curAddr` and has no other effect: no transfer starts and no status bit changes.
- R3: While a transfer runs, each cycle with `wordValid` high adds 4 to `curAddr`. Cycles with `wordValid` low leave it unchanged.
- R4: With transfer mode bit 5 (multi-block) clear, the transfer ends after one block of the programmed length (block size register bits [11:0], select 1), and the block count is left untouched.
- R5: With mode bits 5 and 1 (block count enable) both set, the block count (select 2) drops by one after each full block, and the transfer ends when it reaches zero.
- R6: The boundary is 4096 bytes shifted left by block size bits [14:12]. A word whose address step changes the address bits at or above the boundary size pauses the transfer and sets status bit 3. While paused, `wordReady` is low and `wordValid` is ignored.
- R7: An address write while paused clears the pause, and the transfer continues from the written address with its block position kept.
- R8: When the last word of a transfer also crosses the boundary, the transfer completes and no pause and no bit 3 result.
- R9: Completion sets status bit 0. Writing select 5 clears every status bit given as 1 in the data and leaves those given as 0.
- R10: A start pulse is accepted only while idle, with mode bit 0 (DMA enable) set, host control bits [4:3] (select 4) equal to 00, a nonzero block length, and, for a counted multi-block transfer, a nonzero block count.
- R11: While a transfer is active, writes to the block size, block count, mode and host control registers are ignored.
- R12: `dirRead` follows transfer mode bit 4 (1 = card to host).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 3 | Register select: 0 address, 1 block size, 2 block count, 3 mode, 4 host control, 5 status clear |
| wrData | input | 32 | Write data |
| start | input | 1 | Open a transfer |
| wordValid | input | 1 | A data word moves this cycle |
| wordReady | output | 1 | Words are taken (active and not paused) |
| curAddr | output | 32 | Current system address |
| blkCount | output | 16 | Current block count |
| intStatus | output | 16 | Status: bit 0 done, bit 3 boundary |
| xferActive | output | 1 | Transfer in progress |
| dirRead | output | 1 | Direction, card to host |

## Verification
The hardest state to reach is a pause that lands in the middle of a block. This needs a start address a few words below a boundary and a block long enough to span it. The bench starts at 0xFF8 with a 16-byte block and a 4 KiB boundary, so the second word crosses. It then keeps `wordValid` high through the pause to show those words are dropped, and rewrites the address to finish the block. A second case puts the crossing on the very last word (at 512 KiB) to cover the case where completion takes priority over the pause.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
  typedef enum logic [2:0] {
    SEL_ADDR  = 3'd0,
    SEL_SIZE  = 3'd1,
    SEL_COUNT = 3'd2,
    SEL_MODE  = 3'd3,
    SEL_HOST  = 3'd4,
    SEL_CLEAR = 3'd5
  } regSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadAddr;
    logic loadSize;
    logic loadCount;
    logic loadMode;
    logic loadHost;
    logic clearPos;
    logic advance;
    logic decCount;
  } ctrlStrobe_t;

  localparam int STAT_DONE_BIT = 0;
  localparam int STAT_BND_BIT  = 3;
endpackage

// File: rtl/sdma_datapath.sv
module sdma_datapath #(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 16,
  parameter int SIZE_W     = 12,
  parameter int BND_W      = 3,
  parameter int BASE_SHIFT = 12,
  parameter int WORD_BYTES = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  sdma_pkg::ctrlStrobe_t  strobe,
  input  logic [31:0]            wrData,
  output logic [ADDR_W-1:0]      curAddr,
  output logic [CNT_W-1:0]       blkCount,
  output logic                   blockEnd,
  output logic                   crossing,
  output logic                   sizeZero,
  output logic                   countZero,
  output logic                   countOne,
  output logic                   dmaEn,
  output logic                   cntEn,
  output logic                   multiBlk,
  output logic                   dirRead,
  output logic                   sdmaSel
);
  localparam int POS_W = SIZE_W + 1;
  localparam int SH_W  = $clog2(ADDR_W + 1);

  logic [SIZE_W-1:0] sizeReg;
  logic [BND_W-1:0]  bndReg;
  logic [5:0]        modeReg;
  logic [1:0]        dmaSelReg;
  logic [SIZE_W-1:0] bytePos;
  logic [ADDR_W-1:0] nextAddr;
  logic [POS_W-1:0]  posAfter;
  logic [SH_W-1:0]   shiftAmt;

  assign nextAddr = curAddr + ADDR_W'(WORD_BYTES);
  assign posAfter = {1'b0, bytePos} + POS_W'(WORD_BYTES);
  assign blockEnd = posAfter >= {1'b0, sizeReg};
  assign shiftAmt = SH_W'(BASE_SHIFT) + SH_W'(bndReg);
  assign crossing = ((curAddr ^ nextAddr) >> shiftAmt) != '0;

  assign sizeZero  = sizeReg == '0;
  assign countZero = blkCount == '0;
  assign countOne  = blkCount == CNT_W'(1);
  assign dmaEn     = modeReg[0];
  assign cntEn     = modeReg[1];
  assign dirRead   = modeReg[4];
  assign multiBlk  = modeReg[5];
  assign sdmaSel   = dmaSelReg == 2'b00;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr   <= '0;
      sizeReg   <= '0;
      bndReg    <= '0;
      blkCount  <= '0;
      modeReg   <= '0;
      dmaSelReg <= '0;
      bytePos   <= '0;
    end else begin
      if (strobe.loadAddr)       curAddr <= wrData[ADDR_W-1:0];
      else if (strobe.advance)   curAddr <= nextAddr;
      if (strobe.loadSize) begin
        sizeReg <= wrData[SIZE_W-1:0];
        bndReg  <= wrData[SIZE_W +: BND_W];
      end
      if (strobe.loadCount)      blkCount <= wrData[CNT_W-1:0];
      else if (strobe.decCount)  blkCount <= blkCount - CNT_W'(1);
      if (strobe.loadMode)       modeReg <= wrData[5:0];
      if (strobe.loadHost)       dmaSelReg <= wrData[4:3];
      if (strobe.clearPos)       bytePos <= '0;
      else if (strobe.advance)   bytePos <= blockEnd ? '0 : posAfter[SIZE_W-1:0];
    end
  end

  // R3: a taken word steps the address by one word
  assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance && !strobe.loadAddr |=> curAddr == $past(curAddr) + ADDR_W'(WORD_BYTES));

  // R5: a counted block end lowers the count by one
  assert_count_dec_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.decCount |=> blkCount == $past(blkCount) - CNT_W'(1));
endmodule

// File: rtl/sdma_control.sv
module sdma_control (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic [2:0]             wrSel,
  input  logic [31:0]            wrData,
  input  logic                   start,
  input  logic                   wordValid,
  input  logic                   blockEnd,
  input  logic                   crossing,
  input  logic                   sizeZero,
  input  logic                   countZero,
  input  logic                   countOne,
  input  logic                   dmaEn,
  input  logic                   cntEn,
  input  logic                   multiBlk,
  input  logic                   sdmaSel,
  output sdma_pkg::ctrlStrobe_t  strobe,
  output logic                   wordReady,
  output logic                   xferActive,
  output logic [15:0]            intStatus
);
  import sdma_pkg::*;

  logic    active, paused, statDone, statBnd;
  logic    accept, lastWord, startOk, pauseNow, cfgOk;
  regSel_e sel;

  assign sel       = regSel_e'(wrSel);
  assign wordReady = active && !paused;
  assign accept    = wordValid && wordReady;
  assign lastWord  = accept && blockEnd && (!multiBlk || (cntEn && countOne));
  assign pauseNow  = accept && crossing && !lastWord;
  assign startOk   = start && !active && dmaEn && sdmaSel && !sizeZero &&
                     !(multiBlk && cntEn && countZero);
  assign cfgOk     = wrEn && !active;

  always_comb begin
    strobe           = '0;
    strobe.loadAddr  = wrEn && sel == SEL_ADDR && (!active || paused);
    strobe.loadSize  = cfgOk && sel == SEL_SIZE;
    strobe.loadCount = cfgOk && sel == SEL_COUNT;
    strobe.loadMode  = cfgOk && sel == SEL_MODE;
    strobe.loadHost  = cfgOk && sel == SEL_HOST;
    strobe.clearPos  = startOk;
    strobe.advance   = accept;
    strobe.decCount  = accept && blockEnd && multiBlk && cntEn;
  end

  logic clrDone, clrBnd;
  assign clrDone = wrEn && sel == SEL_CLEAR && wrData[STAT_DONE_BIT];
  assign clrBnd  = wrEn && sel == SEL_CLEAR && wrData[STAT_BND_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active   <= 1'b0;
      paused   <= 1'b0;
      statDone <= 1'b0;
      statBnd  <= 1'b0;
    end else begin
      if (startOk)       active <= 1'b1;
      else if (lastWord) active <= 1'b0;

      if (startOk)              paused <= 1'b0;
      else if (pauseNow)        paused <= 1'b1;
      else if (strobe.loadAddr) paused <= 1'b0;

      if (lastWord)     statDone <= 1'b1;
      else if (clrDone) statDone <= 1'b0;
      if (pauseNow)     statBnd <= 1'b1;
      else if (clrBnd)  statBnd <= 1'b0;
    end
  end

  always_comb begin
    intStatus                = '0;
    intStatus[STAT_DONE_BIT] = statDone;
    intStatus[STAT_BND_BIT]  = statBnd;
  end
  assign xferActive = active;

  // R6: a pause only exists inside an active transfer
  assert_pause_in_xfer_R6: assert property (@(posedge clk) disable iff (!rstN)
    paused |-> active);
  // R6: entering a pause raises the boundary status
  assert_pause_flags_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(paused) |-> statBnd);
  // R7: only an address write leaves a pause
  assert_pause_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    paused && !(wrEn && sel == SEL_ADDR) |=> paused);
  // R9: every end of a transfer reports done
  assert_done_on_end_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(active) |-> statDone);
endmodule

// File: rtl/sdma_xfer_tracker.sv
module sdma_xfer_tracker #(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 16,
  parameter int SIZE_W     = 12,
  parameter int BND_W      = 3,
  parameter int BASE_SHIFT = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        wrSel,
  input  logic [31:0]       wrData,
  input  logic              start,
  input  logic              wordValid,
  output logic              wordReady,
  output logic [ADDR_W-1:0] curAddr,
  output logic [CNT_W-1:0]  blkCount,
  output logic [15:0]       intStatus,
  output logic              xferActive,
  output logic              dirRead
);
  sdma_pkg::ctrlStrobe_t strobe;
  logic blockEnd, crossing, sizeZero, countZero, countOne;
  logic dmaEn, cntEn, multiBlk, sdmaSel;

  sdma_datapath #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .SIZE_W(SIZE_W),
    .BND_W(BND_W), .BASE_SHIFT(BASE_SHIFT), .WORD_BYTES(4)
  ) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .curAddr(curAddr), .blkCount(blkCount), .blockEnd(blockEnd),
    .crossing(crossing), .sizeZero(sizeZero), .countZero(countZero),
    .countOne(countOne), .dmaEn(dmaEn), .cntEn(cntEn), .multiBlk(multiBlk),
    .dirRead(dirRead), .sdmaSel(sdmaSel)
  );

  sdma_control uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .start(start), .wordValid(wordValid), .blockEnd(blockEnd),
    .crossing(crossing), .sizeZero(sizeZero), .countZero(countZero),
    .countOne(countOne), .dmaEn(dmaEn), .cntEn(cntEn), .multiBlk(multiBlk),
    .sdmaSel(sdmaSel), .strobe(strobe), .wordReady(wordReady),
    .xferActive(xferActive), .intStatus(intStatus)
  );
endmodule

// File: tb/sim_sdma_xfer_tracker.sv
module sim_sdma_xfer_tracker;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrSel = '0;
  logic [31:0] wrData = '0;
  logic        start = 1'b0;
  logic        wordValid = 1'b0;
  logic        wordReady, xferActive, dirRead;
  logic [31:0] curAddr;
  logic [15:0] blkCount, intStatus;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdma_xfer_tracker u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .start(start), .wordValid(wordValid), .wordReady(wordReady),
    .curAddr(curAddr), .blkCount(blkCount), .intStatus(intStatus),
    .xferActive(xferActive), .dirRead(dirRead)
  );

  task automatic check(input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", what, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] data);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic pulseStart();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic words(input int n);
    for (int i = 0; i < n; i++) begin
      wordValid = 1'b1;
      @(negedge clk);
    end
    wordValid = 1'b0;
  endtask

  task automatic testReset();
    check("R1 addr", curAddr, 0);
    check("R1 count", {16'h0, blkCount}, 0);
    check("R1 status", {16'h0, intStatus}, 0);
    check("R1 active", {31'h0, xferActive}, 0);
    check("R1 ready", {31'h0, wordReady}, 0);
  endtask

  task automatic testIdleAddr();
    wr(3'd0, 32'h1234_5670);
    check("R2 addr loaded", curAddr, 32'h1234_5670);
    check("R2 no start", {31'h0, xferActive}, 0);
    check("R2 no status", {16'h0, intStatus}, 0);
  endtask

  task automatic testSingle();
    wr(3'd0, 32'h0000_2000);
    wr(3'd1, 32'h0000_0010);          // 16 bytes, 4 KiB boundary
    wr(3'd2, 32'd5);
    wr(3'd3, 32'h0000_0013);          // dma, count enable, read, single
    check("R12 dirRead", {31'h0, dirRead}, 1);
    pulseStart();
    check("R10 started", {31'h0, xferActive}, 1);
    words(1);
    @(negedge clk);                   // idle gap
    check("R3 one word", curAddr, 32'h2004);
    words(3);
    check("R4 ended", {31'h0, xferActive}, 0);
    check("R4 addr", curAddr, 32'h2010);
    check("R4 count untouched", {16'h0, blkCount}, 5);
    check("R9 done bit0", {16'h0, intStatus}, 32'h1);
  endtask

  task automatic testClear();
    wr(3'd5, 32'h0000_0008);
    check("R9 clear zero keeps", {16'h0, intStatus}, 32'h1);
    wr(3'd5, 32'h0000_0001);
    check("R9 clear one", {16'h0, intStatus}, 0);
  endtask

  task automatic testMulti();
    wr(3'd0, 32'h0000_4000);
    wr(3'd1, 32'h0000_0008);
    wr(3'd2, 32'd3);
    wr(3'd3, 32'h0000_0023);          // dma, count enable, write, multi
    check("R12 dirWrite", {31'h0, dirRead}, 0);
    pulseStart();
    words(2);
    check("R5 count after block", {16'h0, blkCount}, 2);
    wr(3'd2, 32'd9);
    wr(3'd1, 32'h0000_0100);
    check("R11 count write ignored", {16'h0, blkCount}, 2);
    words(2);
    check("R5 count two blocks", {16'h0, blkCount}, 1);
    check("R11 size write ignored", curAddr, 32'h4010);
    check("R5 still active", {31'h0, xferActive}, 1);
    words(2);
    check("R5 count zero", {16'h0, blkCount}, 0);
    check("R5 ended", {31'h0, xferActive}, 0);
    check("R5 addr", curAddr, 32'h4018);
    wr(3'd5, 32'h0000_0009);
  endtask

  task automatic testBoundary();
    wr(3'd0, 32'h0000_0FF8);
    wr(3'd1, 32'h0000_0010);          // boundary field 0
    wr(3'd3, 32'h0000_0001);
    pulseStart();
    words(2);
    check("R6 paused addr", curAddr, 32'h1000);
    check("R6 bnd bit3", {16'h0, intStatus}, 32'h8);
    check("R6 ready low", {31'h0, wordReady}, 0);
    words(3);
    check("R6 words ignored", curAddr, 32'h1000);
    wr(3'd0, 32'h0000_1000);
    check("R7 resumed", {31'h0, wordReady}, 1);
    words(2);
    check("R7 finished", curAddr, 32'h1008);
    check("R7 ended", {31'h0, xferActive}, 0);
    check("R7 status", {16'h0, intStatus}, 32'h9);
    wr(3'd5, 32'h0000_0009);
  endtask

  task automatic testLastCross();
    wr(3'd0, 32'h0007_FFF8);
    wr(3'd1, 32'h0000_7008);          // 8 bytes, 512 KiB boundary
    wr(3'd3, 32'h0000_0001);
    pulseStart();
    words(2);
    check("R8 addr", curAddr, 32'h0008_0000);
    check("R8 done only", {16'h0, intStatus}, 32'h1);
    check("R8 ended", {31'h0, xferActive}, 0);
    wr(3'd5, 32'h0000_0001);
    wr(3'd0, 32'h0000_0FF8);
    wr(3'd1, 32'h0000_1010);          // 8 KiB boundary, 16 bytes
    pulseStart();
    words(4);
    check("R6 no pause at 4K with 8K field", curAddr, 32'h1008);
    check("R6 no bnd bit", {16'h0, intStatus}, 32'h1);
    wr(3'd5, 32'h0000_0001);
  endtask

  task automatic testReject();
    wr(3'd4, 32'h0000_0008);          // host control dma select 01
    pulseStart();
    check("R10 non-sdma rejected", {31'h0, xferActive}, 0);
    wr(3'd4, 32'h0000_0000);
    wr(3'd3, 32'h0000_0000);
    pulseStart();
    check("R10 dma off rejected", {31'h0, xferActive}, 0);
    wr(3'd3, 32'h0000_0023);
    wr(3'd2, 32'd0);
    pulseStart();
    check("R10 zero count rejected", {31'h0, xferActive}, 0);
    wr(3'd2, 32'd1);
    pulseStart();
    check("R10 accepted", {31'h0, xferActive}, 1);
    pulseStart();
    words(4);
    check("R10 restart while active ignored", {31'h0, xferActive}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testIdleAddr();
    testSingle();
    testClear();
    testMulti();
    testBoundary();
    testLastCross();
    testReject();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule